// File: doc/BRIEF.md
# Angle-Domain Event Word Generator

This block tracks the angle of a rotating shaft from a quadrature encoder and issues output words at angles that a table lists. The A, B and index lines from the encoder are synchronised and filtered, decoded into forward and reverse steps, and counted into an angle position. The angle runs over one four-stroke engine cycle, which is two shaft revolutions, and then wraps. Each table entry holds an angle setpoint and a data word. When the angle reaches the setpoint of the current entry, the word appears on the parallel output with a one-cycle strobe, and the block moves to the next entry.

A mode input sets the compare resolution. The setpoint can name any single quadrature state, or it can name a whole quadrature cycle, which is counted in units of four states. The table has two banks. The host always writes into the bank that is not running and then requests a swap. The swap takes effect only at the cycle wrap, so a table is never replaced part way through a cycle. One chosen bit of the word is also brought out as a trigger pulse for a downstream time-domain pulse sequencer. The encoder index pulse re-references the angle to the nearest revolution boundary.

Top module: `angle_event_gen`

## Requirements
- R1: While reset is held and just after it is released, angle is 0, evt_word is 0, evt_stb and evt_trig are 0, tbl_idx is 0, act_bank is 0 and err_cnt is 0. Both banks start with every setpoint all ones, so no entry can fire.
- R2: The pin code {enc_a,enc_b} stepping 00→10→11→01→00 adds one to angle for each step. Stepping the other way subtracts one. The angle runs from 0 to CYC-1, where CYC = 2×REV_STATES. Counting forward from CYC-1 gives 0, and counting backward from 0 gives CYC-1.
- R3: A change in which both encoder bits flip at once adds one to err_cnt, which saturates at all ones. Such a change leaves angle unchanged.
- R4: A pulse on an encoder line that lasts fewer than FILT clock cycles is ignored. It changes neither angle nor err_cnt.
- R5: With full_res=1, a step that lands the angle on the setpoint of the current entry produces a one-cycle evt_stb and puts that entry's word on evt_word. This happens within FILT+4 cycles of the pin change. tbl_idx then moves to the next entry.
- R6: With full_res=0, the setpoint is counted in quadrature cycles. An entry fires only when angle mod 4 is 0 and angle/4 equals the setpoint.
- R7: A setpoint of all ones marks the end of the table. Once the last entry (index DEPTH-1) has fired, no further events occur until the next wrap.
- R8: A forward wrap from CYC-1 to 0 resets tbl_idx to 0. If a swap was requested with host_commit, act_bank flips at that wrap, and the act_bank signal changes at no other time. Entry 0 of the table now running can fire at angle 0.
- R9: host_we writes host_angle and host_word into entry host_addr of the bank that is not running. The running table's events are unchanged until a commit and the wrap that follows it.
- R10: On a rising index pulse, angle becomes 0 if it was below REV_STATES/2 or at least 3×REV_STATES/2. Otherwise it becomes REV_STATES. When the load to 0 happens from the upper range, it acts as a wrap as described in R8, and tbl_idx returns to 0.
- R11: evt_trig pulses together with evt_stb exactly when bit TRIG_BIT of the emitted word is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| enc_z | input | 1 | Encoder index pulse (asynchronous) |
| full_res | input | 1 | 1: setpoints in quadrature states, 0: in whole quadrature cycles |
| host_we | input | 1 | Write one entry of the idle bank |
| host_addr | input | IDX_W | Entry index for the write |
| host_angle | input | ANG_W | Setpoint for the write (all ones ends the table) |
| host_word | input | WORD_W | Output word for the write |
| host_commit | input | 1 | Request a bank swap at the next wrap |
| evt_word | output | WORD_W | Word of the most recent event |
| evt_stb | output | 1 | One-cycle event strobe |
| evt_trig | output | 1 | Trigger pulse, which is evt_stb gated by word bit TRIG_BIT |
| angle | output | ANG_W | Current angle in quadrature states |
| tbl_idx | output | IDX_W | Current table entry |
| act_bank | output | 1 | Bank that is running |
| err_cnt | output | ERR_W | Count of illegal encoder transitions |

## Verification
The encoder is driven through legal forward and reverse sequences, across the wrap in both directions, with a double-bit jump and with a single-cycle glitch. This separates correct counting from direction errors, from missed error detection and from a filter that is too short. One table layout is run in both compare modes: a setpoint of 2 fires at state 2 in full resolution but at state 8 in cycle mode, which shows whether the scaling is right. Writes to the idle bank made without a commit must leave the running events unchanged over a later wrap. An armed swap must take effect only after the wrap. Index pulses are applied in the middle and upper angle ranges and close to zero, which separates the nearest-boundary rule and the wrap it implies from a plain clear.

// File: rtl/angle_event_gen.sv
module angle_event_gen #(
  parameter int REV_STATES = 5760,
  parameter int DEPTH      = 16,
  parameter int WORD_W     = 16,
  parameter int FILT       = 3,
  parameter int TRIG_BIT   = 0,
  parameter int ERR_W      = 8,
  localparam int CYC   = 2 * REV_STATES,
  localparam int ANG_W = $clog2(CYC),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_z,
  input  logic              full_res,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [ANG_W-1:0]  host_angle,
  input  logic [WORD_W-1:0] host_word,
  input  logic              host_commit,
  output logic [WORD_W-1:0] evt_word,
  output logic              evt_stb,
  output logic              evt_trig,
  output logic [ANG_W-1:0]  angle,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              act_bank,
  output logic [ERR_W-1:0]  err_cnt
);
  localparam int FLT_W = $clog2(FILT + 1);
  localparam logic [ANG_W-1:0] LAST_ANG = ANG_W'(CYC - 1);
  localparam logic [ANG_W-1:0] REV_ANG  = ANG_W'(REV_STATES);
  localparam logic [ANG_W-1:0] LO_EDGE  = ANG_W'(REV_STATES / 2);
  localparam logic [ANG_W-1:0] HI_EDGE  = ANG_W'(CYC - REV_STATES / 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [ANG_W-1:0] END_MARK = '1;

  logic [2:0] raw, meta, sync, flt;
  assign raw = {enc_z, enc_b, enc_a};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= raw;
      sync <= meta;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < 3; ch++) begin : g_filt
      logic [FLT_W-1:0] cnt;
      logic             val;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
          val <= 1'b0;
        end else if (sync[ch] == val) begin
          cnt <= '0;
        end else if (cnt == FLT_W'(FILT - 1)) begin
          val <= sync[ch];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign flt[ch] = val;
    end
  endgenerate

  function automatic logic [1:0] phase_of(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

  logic [1:0] prv_ab, cur_ab, dph;
  logic       z_prv, z_rise, step_f, step_r, illegal;
  assign cur_ab  = {flt[0], flt[1]};
  assign dph     = phase_of(cur_ab) - phase_of(prv_ab);
  assign step_f  = (dph == 2'd1);
  assign step_r  = (dph == 2'd3);
  assign illegal = (dph == 2'd2);
  assign z_rise  = flt[2] & ~z_prv;

  logic moved_q, wrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv_ab  <= '0;
      z_prv   <= 1'b0;
      angle   <= '0;
      moved_q <= 1'b0;
      wrap_q  <= 1'b0;
      err_cnt <= '0;
    end else begin
      prv_ab  <= cur_ab;
      z_prv   <= flt[2];
      moved_q <= 1'b0;
      wrap_q  <= 1'b0;
      if (illegal && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
      if (z_rise) begin
        if (angle < LO_EDGE || angle >= HI_EDGE) angle <= '0;
        else                                   angle <= REV_ANG;
        wrap_q <= (angle >= HI_EDGE);
      end else if (step_f) begin
        angle   <= (angle == LAST_ANG) ? '0 : angle + 1'b1;
        moved_q <= 1'b1;
        wrap_q  <= (angle == LAST_ANG);
      end else if (step_r) begin
        angle   <= (angle == '0) ? LAST_ANG : angle - 1'b1;
        moved_q <= 1'b1;
      end
    end
  end

  logic [ANG_W-1:0]  sp_mem [2][DEPTH];
  logic [WORD_W-1:0] wd_mem [2][DEPTH];
  logic              armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < DEPTH; k++) begin
          sp_mem[b][k] <= END_MARK;
          wd_mem[b][k] <= '0;
        end
      armed    <= 1'b0;
      act_bank <= 1'b0;
    end else begin
      if (host_we) begin
        sp_mem[~act_bank][host_addr] <= host_angle;
        wd_mem[~act_bank][host_addr] <= host_word;
      end
      armed    <= host_commit | (armed & ~wrap_q);
      act_bank <= act_bank ^ (wrap_q & armed);
    end
  end

  logic              bank_n, done, done_n, hit, fire;
  logic [IDX_W-1:0]  idx_n;
  logic [ANG_W-1:0]  sp;
  logic [WORD_W-1:0] wd;
  assign bank_n = wrap_q ? (act_bank ^ armed) : act_bank;
  assign idx_n  = wrap_q ? '0 : tbl_idx;
  assign done_n = wrap_q ? 1'b0 : done;
  assign sp     = sp_mem[bank_n][idx_n];
  assign wd     = wd_mem[bank_n][idx_n];
  assign hit    = full_res ? (angle == sp)
                           : (angle[1:0] == 2'b00 && {2'b00, angle[ANG_W-1:2]} == sp);
  assign fire   = moved_q && !done_n && sp != END_MARK && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_idx  <= '0;
      done     <= 1'b0;
      evt_stb  <= 1'b0;
      evt_trig <= 1'b0;
      evt_word <= '0;
    end else begin
      tbl_idx  <= idx_n;
      done     <= done_n;
      evt_stb  <= fire;
      evt_trig <= fire & wd[TRIG_BIT];
      if (fire) begin
        evt_word <= wd;
        if (idx_n == LAST_IDX) done <= 1'b1;
        else                   tbl_idx <= idx_n + 1'b1;
      end
    end
  end

  assert_angle_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    angle <= LAST_ANG);
  assert_illegal_holds_angle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal && !z_rise |=> angle == $past(angle));
  assert_illegal_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal && err_cnt != '1 |=> err_cnt == $past(err_cnt) + 1'b1);
  assert_event_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |-> $past(moved_q));
  assert_quiet_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) && !$past(wrap_q) |-> !evt_stb);
  assert_swap_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_bank != $past(act_bank) |-> $past(wrap_q));
  assert_trig_with_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |-> evt_stb && evt_word[TRIG_BIT]);
endmodule

// File: tb/angle_event_gen_test.sv
module angle_event_gen_test;
  localparam int REV = 40;
  localparam int CYC = 2 * REV;
  localparam int DEPTH = 4;
  localparam int AW = $clog2(CYC);
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0, full_res = 1'b1;
  logic host_we = 1'b0, host_commit = 1'b0;
  logic [IW-1:0] host_addr = '0;
  logic [AW-1:0] host_angle = '0;
  logic [15:0] host_word = '0;
  logic [15:0] evt_word;
  logic evt_stb, evt_trig, act_bank;
  logic [AW-1:0] angle;
  logic [IW-1:0] tbl_idx;
  logic [7:0] err_cnt;

  always #5 clk = ~clk;

  angle_event_gen #(.REV_STATES(REV), .DEPTH(DEPTH), .WORD_W(16), .FILT(3),
                    .TRIG_BIT(0), .ERR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .full_res(full_res), .host_we(host_we), .host_addr(host_addr),
    .host_angle(host_angle), .host_word(host_word), .host_commit(host_commit),
    .evt_word(evt_word), .evt_stb(evt_stb), .evt_trig(evt_trig), .angle(angle),
    .tbl_idx(tbl_idx), .act_bank(act_bank), .err_cnt(err_cnt));

  int total = 0, bad = 0;
  int stb_n = 0, trig_n = 0;
  logic [15:0] last_word = '0;
  int ph = 0, mpos = 0;

  always @(negedge clk)
    if (rst_n && evt_stb) begin
      stb_n++;
      last_word = evt_word;
      if (evt_trig) trig_n++;
    end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_ph(input int p);
    case (p & 3)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b10;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b01;
    endcase
  endtask

  task automatic step(input bit fwd);
    @(negedge clk);
    ph = fwd ? (ph + 1) & 3 : (ph + 3) & 3;
    drive_ph(ph);
    mpos = fwd ? (mpos + 1) % CYC : (mpos + CYC - 1) % CYC;
    repeat (12) @(negedge clk);
  endtask

  task automatic go_to(input int target);
    while (mpos != target) step(1'b1);
  endtask

  task automatic wr(input int a, input int ang, input int w);
    @(negedge clk);
    host_we = 1'b1; host_addr = IW'(a); host_angle = AW'(ang); host_word = 16'(w);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); host_commit = 1'b1;
    @(negedge clk); host_commit = 1'b0;
  endtask

  task automatic pulse_index();
    @(negedge clk); enc_z = 1'b1;
    repeat (12) @(negedge clk);
    enc_z = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "angle", int'(angle), 0);
    check("R1", "evt_word", int'(evt_word), 0);
    check("R1", "evt_stb", int'(evt_stb), 0);
    check("R1", "tbl_idx", int'(tbl_idx), 0);
    check("R1", "act_bank", int'(act_bank), 0);
    check("R1", "err_cnt", int'(err_cnt), 0);
  endtask

  task automatic t_count();
    repeat (5) step(1'b1);
    check("R2", "fwd angle", int'(angle), 5);
    repeat (7) step(1'b0);
    check("R2", "rev wrap angle", int'(angle), CYC - 2);
    repeat (2) step(1'b1);
    check("R2", "fwd wrap angle", int'(angle), 0);
    check("R1", "empty table no events", stb_n, 0);
  endtask

  task automatic t_illegal();
    @(negedge clk);
    ph = (ph + 2) & 3;
    drive_ph(ph);
    repeat (12) @(negedge clk);
    check("R3", "err_cnt", int'(err_cnt), 1);
    check("R3", "angle held", int'(angle), mpos);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    drive_ph(ph + 1);
    @(negedge clk);
    drive_ph(ph);
    repeat (12) @(negedge clk);
    check("R4", "angle after glitch", int'(angle), mpos);
    check("R4", "err after glitch", int'(err_cnt), 1);
  endtask

  task automatic t_table_full();
    full_res = 1'b1;
    wr(0, 3, 16'hA001);
    wr(1, 7, 16'h0002);
    wr(2, 127, 0);
    commit();
    go_to(CYC - 1);
    check("R9", "no events before swap", stb_n, 0);
    check("R8", "bank before wrap", int'(act_bank), 0);
    go_to(0);
    check("R8", "bank after wrap", int'(act_bank), 1);
    go_to(3);
    check("R5", "events at 3", stb_n, 1);
    check("R5", "word at 3", int'(last_word), 16'hA001);
    check("R11", "trig at 3", trig_n, 1);
    check("R5", "idx after 3", int'(tbl_idx), 1);
    go_to(7);
    check("R5", "events at 7", stb_n, 2);
    check("R5", "word at 7", int'(last_word), 16'h0002);
    check("R11", "no trig at 7", trig_n, 1);
    go_to(30);
    check("R7", "end marker quiet", stb_n, 2);
    check("R7", "idx at end marker", int'(tbl_idx), 2);
  endtask

  task automatic t_shadow();
    wr(0, 10, 16'h5555);
    go_to(0);
    check("R8", "idx reset on wrap", int'(tbl_idx), 0);
    go_to(12);
    check("R9", "running table kept", stb_n, 4);
    check("R9", "shadow word not used", int'(last_word), 16'h0002);
    check("R9", "bank unchanged", int'(act_bank), 1);
  endtask

  task automatic t_cycle_mode();
    int s0, t0;
    full_res = 1'b0;
    wr(0, 2, 16'h1110);
    wr(1, 3, 16'h1111);
    wr(2, 4, 16'h1112);
    wr(3, 5, 16'h1113);
    commit();
    go_to(0);
    check("R8", "bank swapped back", int'(act_bank), 0);
    s0 = stb_n; t0 = trig_n;
    go_to(9);
    check("R6", "only state 8 fired", stb_n - s0, 1);
    check("R6", "word at 8", int'(last_word), 16'h1110);
    go_to(21);
    check("R6", "events through 20", stb_n - s0, 4);
    check("R6", "word at 20", int'(last_word), 16'h1113);
    check("R11", "trig count", trig_n - t0, 2);
    go_to(24);
    check("R7", "quiet after last entry", stb_n - s0, 4);
    check("R7", "idx held at last", int'(tbl_idx), 3);
  endtask

  task automatic t_index();
    int s0;
    pulse_index();
    mpos = REV;
    check("R10", "mid index to REV", int'(angle), REV);
    check("R10", "mid index no wrap", int'(tbl_idx), 3);
    go_to(65);
    pulse_index();
    mpos = 0;
    check("R10", "upper index to 0", int'(angle), 0);
    check("R10", "upper index wraps", int'(tbl_idx), 0);
    s0 = stb_n;
    go_to(8);
    check("R10", "entry 0 after index wrap", stb_n - s0, 1);
    check("R10", "idx after event", int'(tbl_idx), 1);
    pulse_index();
    mpos = 0;
    check("R10", "low index to 0", int'(angle), 0);
    check("R10", "low index no wrap", int'(tbl_idx), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_count();
    t_illegal();
    t_glitch();
    t_table_full();
    t_shadow();
    t_cycle_mode();
    t_index();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule